// File: doc/BRIEF.md
# Memory Block Copy and Compare Sequencer

This block runs byte-string moves and byte searches against a synchronous byte memory. A caller loads a source pointer, a destination pointer, a 24-bit count, an accumulator byte and a six-bit flag word, then pulses `start`. Each pass reads one byte at the source pointer. A move writes that byte to the destination. A compare subtracts it from the accumulator and keeps only the flags. The pointers then step up or down and the count drops by one. A pass is single-shot or repeats until the count runs out or, for a compare, until the byte matches.

Addresses are formed in one of two modes. In wide mode a register is used as a full 24-bit address. In short mode only its low 16 bits are used, and an 8-bit base value supplies the upper address byte. A pending-interrupt input can park a repeating run between passes, with every register consistent. A later `start` with `resume` set continues the run from the held state. The block also keeps a running total of internal cycles so that callers can bill time the way the instruction set does.

Top module: `blk_seq`

## Requirements
- R1: A `start` seen while `busy` is low is accepted and `busy` rises on the next cycle. A `start` seen while `busy` is high is ignored. Completion is marked by `done` high for exactly one cycle, with `busy` low in that cycle and the result outputs valid.
- R2: Each pass takes three cycles. In the first, `mem_rd` is high and addresses the source pointer. In the second, a move drives `mem_wr` with the returned byte at the destination. The third cycle updates the registers. `mem_rd` and `mem_wr` are never high together, and `done` comes 3×passes+1 cycles after the accepting edge.
- R3: A move clears H and N, sets PV to (count after decrement ≠ 0), and keeps S, Z and C. The flag word is {S,Z,H,PV,N,C} on bits 5 down to 0.
- R4: A compare sets S and Z from the byte result of accumulator minus the read byte. It sets H when the low nibble of the accumulator is below that of the byte, sets N, keeps C and sets PV as in R3. A compare never writes memory and never changes the destination pointer.
- R5: With `dir_dn` at 0 the pointers step by +1 after each pass; with `dir_dn` at 1 they step by −1.
- R6: A move with `rpt` at 0 does one pass. With `rpt` at 1 it repeats while PV is 1.
- R7: A repeating compare stops after the pass that gives Z = 1 or PV = 0, whichever comes first.
- R8: `icycles` is cleared by a fresh start and grows by 1 per pass. The exception is a repeating compare pass that is followed by another pass, or by a suspension, which adds 2.
- R9: In wide mode (`wide` = 1) the memory address is the 24-bit register value, and pointer steps wrap modulo 2^24.
- R10: In short mode the memory address is {`base`, register[15:0]}. After a step, pointers hold only their low 16 bits, so the upper byte reads 0 and 0xFFFF+1 becomes 0.
- R11: In short mode the count decrements only in its low 16 bits and keeps its upper byte. PV then reflects only those low 16 bits.
- R12: `irq_pend` is looked at only in the update cycle, and only when another pass would follow. If it is high then, the run ends with `done` and `suspended` = 1 and the registers as of that pass. A later `start` with `resume` = 1 ignores the load inputs and continues with the next pass.

Port table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| resume | input | 1 | With start: continue from held state instead of loading |
| op_cmp | input | 1 | 0 = move, 1 = compare |
| dir_dn | input | 1 | 0 = step up, 1 = step down |
| rpt | input | 1 | 1 = repeat until done |
| wide | input | 1 | 1 = 24-bit addressing, 0 = short addressing with base |
| base | input | 8 | Upper address byte in short mode |
| hl_in | input | 24 | Initial source pointer |
| de_in | input | 24 | Initial destination pointer |
| bc_in | input | 24 | Initial count |
| acc_in | input | 8 | Accumulator for compare |
| flags_in | input | 6 | Initial flags {S,Z,H,PV,N,C} |
| irq_pend | input | 1 | Pending interrupt, may park a repeating run |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| suspended | output | 1 | Last run was parked by irq_pend |
| hl_out | output | 24 | Source pointer |
| de_out | output | 24 | Destination pointer |
| bc_out | output | 24 | Count |
| flags_out | output | 6 | Flags {S,Z,H,PV,N,C} |
| icycles | output | 16 | Internal cycle total of the run |

## Verification
The two functions that meet in a single cycle are the repeat-continue decision and the interrupt sample, since both are taken in the update cycle. The bench provokes this in three ways. It holds `irq_pend` high through repeating runs, through single-step runs and through final passes. It also raises `irq_pend` only outside the update cycles. Each case is judged by `suspended`, the parked pointer and count values, the cycle total and the resumed final result. A compare that hits both a match and an exhausted count on the same pass is also covered.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;

    localparam int BS_AW = 24;
    localparam int BS_SW = 16;
    localparam int BS_DW = 8;
    localparam int BS_HW = BS_AW - BS_SW;

    typedef logic [BS_AW-1:0] addr_t;
    typedef logic [BS_DW-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_XF   = 2'd2,
        ST_UPD  = 2'd3
    } st_e;

    // bit 5 down to 0: S Z H PV N C
    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        logic  is_cmp;
        logic  dn;
        logic  rpt;
        logic  wide;
        byte_t base;
    } mode_t;

    typedef struct packed {
        addr_t hl;
        addr_t de;
        addr_t bc;
        byte_t acc;
    } regs_t;

    function automatic addr_t form_addr(addr_t v, logic wide, byte_t base);
        return wide ? v : {base, v[BS_SW-1:0]};
    endfunction

    function automatic addr_t step_ptr(addr_t v, logic dn, logic wide);
        addr_t t;
        t = dn ? v - addr_t'(1) : v + addr_t'(1);
        return wide ? t : {{BS_HW{1'b0}}, t[BS_SW-1:0]};
    endfunction

    function automatic addr_t dec_cnt(addr_t v, logic wide);
        logic [BS_SW-1:0] lo;
        lo = v[BS_SW-1:0] - 1'b1;
        return wide ? v - addr_t'(1) : {v[BS_AW-1:BS_SW], lo};
    endfunction

    function automatic logic cnt_live(addr_t v, logic wide);
        return wide ? (v != '0) : (v[BS_SW-1:0] != '0);
    endfunction

endpackage

// File: rtl/blk_seq_fsm.sv
module blk_seq_fsm
    import blk_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cont,
    input  logic irq_pend,
    output st_e  st,
    output logic load,
    output logic done,
    output logic susp
);

    assign load = (st == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
            susp <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_RD;
                        susp <= 1'b0;
                    end
                end
                ST_RD: st <= ST_XF;
                ST_XF: st <= ST_UPD;
                ST_UPD: begin
                    if (cont && !irq_pend) begin
                        st <= ST_RD;
                    end else begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                        susp <= cont && irq_pend;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/blk_seq_cmp.sv
module blk_seq_cmp
    import blk_seq_pkg::*;
(
    input  byte_t a,
    input  byte_t b,
    output logic  s,
    output logic  z,
    output logic  h
);

    byte_t diff;

    always_comb begin
        diff = a - b;
        s    = diff[BS_DW-1];
        z    = (diff == '0);
        h    = (a[3:0] < b[3:0]);
    end

endmodule

// File: rtl/blk_seq_regs.sv
module blk_seq_regs
    import blk_seq_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             resume,
    input  mode_t            mode_in,
    input  regs_t            regs_in,
    input  flags_t           flags_in,
    input  st_e              st,
    input  byte_t            rdata,
    input  logic             cmp_s,
    input  logic             cmp_z,
    input  logic             cmp_h,
    output regs_t            regs_q,
    output flags_t           flags_q,
    output mode_t            mode_q,
    output byte_t            dbyte_q,
    output logic [CYC_W-1:0] icyc_q,
    output logic             cont
);

    regs_t            nregs;
    flags_t           nflags;
    logic             live;
    logic [CYC_W-1:0] cost;

    always_comb begin
        nregs     = regs_q;
        nregs.bc  = dec_cnt(regs_q.bc, mode_q.wide);
        nregs.hl  = step_ptr(regs_q.hl, mode_q.dn, mode_q.wide);
        if (!mode_q.is_cmp)
            nregs.de = step_ptr(regs_q.de, mode_q.dn, mode_q.wide);
        live = cnt_live(nregs.bc, mode_q.wide);

        nflags    = flags_q;
        nflags.pv = live;
        if (mode_q.is_cmp) begin
            nflags.s = cmp_s;
            nflags.z = cmp_z;
            nflags.h = cmp_h;
            nflags.n = 1'b1;
        end else begin
            nflags.h = 1'b0;
            nflags.n = 1'b0;
        end

        cont = mode_q.rpt && live && !(mode_q.is_cmp && cmp_z);
        cost = (mode_q.is_cmp && mode_q.rpt && cont) ? CYC_W'(2) : CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q  <= '0;
            flags_q <= '0;
            mode_q  <= '0;
            dbyte_q <= '0;
            icyc_q  <= '0;
        end else if (load) begin
            if (!resume) begin
                regs_q  <= regs_in;
                flags_q <= flags_in;
                mode_q  <= mode_in;
                icyc_q  <= '0;
            end
        end else if (st == ST_XF) begin
            dbyte_q <= rdata;
        end else if (st == ST_UPD) begin
            regs_q  <= nregs;
            flags_q <= nflags;
            icyc_q  <= icyc_q + cost;
        end
    end

endmodule

// File: rtl/blk_seq.sv
module blk_seq
    import blk_seq_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               resume,
    input  logic               op_cmp,
    input  logic               dir_dn,
    input  logic               rpt,
    input  logic               wide,
    input  logic [BS_DW-1:0]   base,
    input  logic [BS_AW-1:0]   hl_in,
    input  logic [BS_AW-1:0]   de_in,
    input  logic [BS_AW-1:0]   bc_in,
    input  logic [BS_DW-1:0]   acc_in,
    input  logic [5:0]         flags_in,
    input  logic               irq_pend,
    output logic [BS_AW-1:0]   mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [BS_DW-1:0]   mem_wdata,
    input  logic [BS_DW-1:0]   mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               suspended,
    output logic [BS_AW-1:0]   hl_out,
    output logic [BS_AW-1:0]   de_out,
    output logic [BS_AW-1:0]   bc_out,
    output logic [5:0]         flags_out,
    output logic [CYC_W-1:0]   icycles
);

    st_e    st;
    logic   load;
    logic   cont;
    regs_t  regs_q;
    flags_t flags_q;
    mode_t  mode_q;
    byte_t  dbyte_q;
    mode_t  mode_in;
    regs_t  regs_in;
    logic   cmp_s, cmp_z, cmp_h;
    logic   md_cmp;
    logic   md_wide;
    byte_t  md_base;

    assign mode_in = '{is_cmp: op_cmp, dn: dir_dn, rpt: rpt, wide: wide, base: base};
    assign regs_in = '{hl: hl_in, de: de_in, bc: bc_in, acc: acc_in};

    blk_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cont     (cont),
        .irq_pend (irq_pend),
        .st       (st),
        .load     (load),
        .done     (done),
        .susp     (suspended)
    );

    blk_seq_cmp u_cmp (
        .a (regs_q.acc),
        .b (dbyte_q),
        .s (cmp_s),
        .z (cmp_z),
        .h (cmp_h)
    );

    blk_seq_regs #(.CYC_W(CYC_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .resume   (resume),
        .mode_in  (mode_in),
        .regs_in  (regs_in),
        .flags_in (flags_t'(flags_in)),
        .st       (st),
        .rdata    (mem_rdata),
        .cmp_s    (cmp_s),
        .cmp_z    (cmp_z),
        .cmp_h    (cmp_h),
        .regs_q   (regs_q),
        .flags_q  (flags_q),
        .mode_q   (mode_q),
        .dbyte_q  (dbyte_q),
        .icyc_q   (icycles),
        .cont     (cont)
    );

    assign md_cmp  = mode_q.is_cmp;
    assign md_wide = mode_q.wide;
    assign md_base = mode_q.base;

    always_comb begin
        mem_rd    = (st == ST_RD);
        mem_wr    = (st == ST_XF) && !md_cmp;
        mem_wdata = mem_rdata;
        mem_addr  = (st == ST_XF) ? form_addr(regs_q.de, md_wide, md_base)
                                  : form_addr(regs_q.hl, md_wide, md_base);
    end

    assign busy      = (st != ST_IDLE);
    assign hl_out    = regs_q.hl;
    assign de_out    = regs_q.de;
    assign bc_out    = regs_q.bc;
    assign flags_out = flags_q;

endmodule

// File: rtl/blk_seq_chk.sv
module blk_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [23:0] mem_addr,
    input logic        done,
    input logic        busy,
    input logic        susp,
    input logic        irq_pend,
    input logic        md_cmp,
    input logic        md_wide,
    input logic [7:0]  md_base
);

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R2

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd)); // R2

    AST_CMP_NO_WR: assert property (@(posedge clk) disable iff (rst)
        (busy && md_cmp) |-> !mem_wr); // R4

    AST_SHORT_BASE: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !md_wide) |-> (mem_addr[23:16] == md_base)); // R10

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R1

    AST_SUSP_IRQ: assert property (@(posedge clk) disable iff (rst)
        (done && susp) |-> $past(irq_pend)); // R12

endmodule

bind blk_seq blk_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .done     (done),
    .busy     (busy),
    .susp     (suspended),
    .irq_pend (irq_pend),
    .md_cmp   (md_cmp),
    .md_wide  (md_wide),
    .md_base  (md_base)
);

// File: tb/blk_seq_bench.sv
module blk_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, resume = 1'b0, op_cmp = 1'b0, dir_dn = 1'b0, rpt = 1'b0, wide = 1'b1;
    logic [7:0]  base = '0, acc_in = '0;
    logic [23:0] hl_in = '0, de_in = '0, bc_in = '0;
    logic [5:0]  flags_in = '0;
    logic        irq_pend = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, suspended;
    logic [23:0] hl_out, de_out, bc_out;
    logic [5:0]  flags_out;
    logic [15:0] icycles;

    always #2 clk = ~clk;

    blk_seq u_blk_seq (
        .clk(clk), .rst(rst), .start(start), .resume(resume), .op_cmp(op_cmp),
        .dir_dn(dir_dn), .rpt(rpt), .wide(wide), .base(base), .hl_in(hl_in),
        .de_in(de_in), .bc_in(bc_in), .acc_in(acc_in), .flags_in(flags_in),
        .irq_pend(irq_pend), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .suspended(suspended), .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
        .flags_out(flags_out), .icycles(icycles)
    );

    logic [7:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic mem_init();
        for (int i = 0; i < 1024; i++) mem[i] = i[7:0];
    endtask

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        cmp, dn, rp, wd;
        logic [7:0]  bs;
        logic [23:0] hl, de, bc;
        logic [7:0]  acc;
        logic [5:0]  fl;
        logic [23:0] ehl, ede, ebc;
        logic [5:0]  efl;
        logic [15:0] eic;
        logic [7:0]  nit;
        logic [23:0] erd, ewr;
        logic [7:0]  nwr;
        logic [9:0]  cidx;
        logic [7:0]  cval;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // move single up
        '{1'b0,1'b0,1'b0,1'b1,8'h00,24'h000100,24'h000200,24'h000005,8'h00,6'b000000,
          24'h000101,24'h000201,24'h000004,6'b000100,16'd1,8'd1,24'h000100,24'h000200,8'd1,10'h200,8'h00},
        // move repeat up, S Z C kept
        '{1'b0,1'b0,1'b1,1'b1,8'h00,24'h000100,24'h000300,24'h000004,8'h00,6'b110011,
          24'h000104,24'h000304,24'h000000,6'b110001,16'd4,8'd4,24'h000100,24'h000300,8'd4,10'h303,8'h03},
        // move repeat down
        '{1'b0,1'b1,1'b1,1'b1,8'h00,24'h0001F3,24'h0002F3,24'h000003,8'h00,6'b000000,
          24'h0001F0,24'h0002F0,24'h000000,6'b000000,16'd3,8'd3,24'h0001F3,24'h0002F3,8'd3,10'h2F1,8'hF1},
        // compare repeat, match on pass 20
        '{1'b1,1'b0,1'b1,1'b1,8'h00,24'h000010,24'h000055,24'h000040,8'h23,6'b000001,
          24'h000024,24'h000055,24'h00002C,6'b010111,16'd39,8'd20,24'h000010,24'h0,8'd0,10'h0,8'h0},
        // compare repeat, count exhausted
        '{1'b1,1'b0,1'b1,1'b1,8'h00,24'h000020,24'h000055,24'h000003,8'hFF,6'b000000,
          24'h000023,24'h000055,24'h000000,6'b100010,16'd5,8'd3,24'h000020,24'h0,8'd0,10'h0,8'h0},
        // compare single down, half borrow
        '{1'b1,1'b1,1'b0,1'b1,8'h00,24'h000017,24'h000055,24'h000001,8'h05,6'b000000,
          24'h000016,24'h000055,24'h000000,6'b101010,16'd1,8'd1,24'h000017,24'h0,8'd0,10'h0,8'h0},
        // compare single, wide count wraps from 0
        '{1'b1,1'b0,1'b0,1'b1,8'h00,24'h000040,24'h000055,24'h000000,8'h00,6'b000000,
          24'h000041,24'h000055,24'hFFFFFF,6'b100110,16'd1,8'd1,24'h000040,24'h0,8'd0,10'h0,8'h0},
        // short move, base 12, HL FFFF wraps to 0
        '{1'b0,1'b0,1'b0,1'b0,8'h12,24'hABFFFF,24'h000080,24'h770000,8'h00,6'b000000,
          24'h000000,24'h000081,24'h77FFFF,6'b000100,16'd1,8'd1,24'h12FFFF,24'h120080,8'd1,10'h080,8'hFF},
        // wide move down, HL 0 wraps to FFFFFF
        '{1'b0,1'b1,1'b0,1'b1,8'h00,24'h000000,24'h000005,24'h000001,8'h00,6'b000000,
          24'hFFFFFF,24'h000004,24'h000000,6'b000000,16'd1,8'd1,24'h000000,24'h000005,8'd1,10'h005,8'h00},
        // short compare, count low half wraps
        '{1'b1,1'b0,1'b0,1'b0,8'h00,24'h990010,24'h000055,24'h350000,8'h00,6'b000000,
          24'h000011,24'h000055,24'h35FFFF,6'b100110,16'd1,8'd1,24'h000010,24'h0,8'd0,10'h0,8'h0},
        // short move, base 07, PV from low 16 bits only
        '{1'b0,1'b0,1'b0,1'b0,8'h07,24'h000000,24'h00FFFF,24'h350001,8'h00,6'b000000,
          24'h000001,24'h000000,24'h350000,6'b000000,16'd1,8'd1,24'h070000,24'h07FFFF,8'd1,10'h3FF,8'h00}
    };

    logic [23:0] r_rd, r_wr;
    int          r_rdc, r_wrc, r_nwr, r_dcyc;
    bit          r_dnext, r_susp, r_busy1;

    // irqm: 0 never, 1 always, 2 only outside update cycles
    task automatic run(input vec_t v, input int irqm, input bit res, input bit noise);
        int cyc;
        @(negedge clk);
        start = 1'b1; resume = res;
        op_cmp = v.cmp; dir_dn = v.dn; rpt = v.rp; wide = v.wd; base = v.bs;
        hl_in = res ? 24'h3C3C3C : v.hl; de_in = res ? 24'h3C3C3C : v.de;
        bc_in = res ? 24'h000777 : v.bc; acc_in = v.acc; flags_in = v.fl;
        irq_pend = (irqm != 0);
        @(negedge clk);
        start = 1'b0; resume = 1'b0;
        r_busy1 = busy;
        cyc = 1; r_rdc = 0; r_wrc = 0; r_nwr = 0; r_rd = '0; r_wr = '0; r_dcyc = 0;
        while (cyc < 4000) begin
            if (mem_rd && r_rdc == 0) begin r_rdc = cyc; r_rd = mem_addr; end
            if (mem_wr) begin
                if (r_wrc == 0) begin r_wrc = cyc; r_wr = mem_addr; end
                r_nwr++;
            end
            if (done) begin r_dcyc = cyc; r_susp = suspended; break; end
            irq_pend = (irqm == 1) || (irqm == 2 && (cyc % 3) != 0);
            if (noise && cyc == 2) begin start = 1'b1; hl_in = 24'h0003AA; bc_in = 24'h000001; end
            if (noise && cyc == 3) start = 1'b0;
            cyc++;
            @(negedge clk);
        end
        irq_pend = 1'b0;
        if (r_dcyc == 0) chk(0, "R1 watchdog no done", 32'(cyc), 32'd0);
        @(negedge clk);
        r_dnext = done;
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        chk(r_busy1 == 1'b1, {tag, " R1 busy after start"}, 32'(r_busy1), 32'd1);
        chk(r_dnext == 1'b0, {tag, " R1 done one cycle"}, 32'(r_dnext), 32'd0);
        chk(hl_out == v.ehl, {tag, " R5 R9 R10 hl"}, 32'(hl_out), 32'(v.ehl));
        chk(de_out == v.ede, {tag, " R4 R5 R10 de"}, 32'(de_out), 32'(v.ede));
        chk(bc_out == v.ebc, {tag, " R6 R7 R11 bc"}, 32'(bc_out), 32'(v.ebc));
        chk(flags_out == v.efl, {tag, " R3 R4 R11 flags"}, 32'(flags_out), 32'(v.efl));
        chk(icycles == v.eic, {tag, " R8 icycles"}, 32'(icycles), 32'(v.eic));
        chk(r_dcyc == 3 * int'(v.nit) + 1, {tag, " R2 done cycle"}, 32'(r_dcyc), 32'(3 * int'(v.nit) + 1));
        chk(r_rdc == 1 && r_rd == v.erd, {tag, " R2 R9 R10 read addr"}, 32'(r_rd), 32'(v.erd));
        chk(r_nwr == int'(v.nwr), {tag, " R2 R4 write count"}, 32'(r_nwr), 32'(v.nwr));
        if (v.nwr != 0) begin
            chk(r_wrc == 2 && r_wr == v.ewr, {tag, " R2 R10 write addr"}, 32'(r_wr), 32'(v.ewr));
            chk(mem[v.cidx] == v.cval, {tag, " R2 R3 moved byte"}, 32'(mem[v.cidx]), 32'(v.cval));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        mem_init();
        repeat (3) @(negedge clk);
        // reset state, R1
        chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R2 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            mem_init();
            run(VECS[i], 0, 1'b0, 1'b0);
            check_vec(VECS[i], $sformatf("vec%0d", i));
            chk(r_susp == 1'b0, $sformatf("vec%0d R12 no suspend", i), 32'(r_susp), 32'd0);
        end

        // R1: start while busy ignored
        mem_init();
        run(VECS[1], 0, 1'b0, 1'b1);
        check_vec(VECS[1], "busy-start");

        // R12: suspend after first pass, then resume
        mem_init();
        v = VECS[1];
        v.bc = 24'd6;
        run(v, 1, 1'b0, 1'b0);
        chk(r_susp == 1'b1, "R12 suspended", 32'(r_susp), 32'd1);
        chk(r_dcyc == 4, "R12 parked after one pass", 32'(r_dcyc), 32'd4);
        chk(hl_out == 24'h101 && de_out == 24'h301, "R12 parked pointers", 32'(hl_out), 32'h101);
        chk(bc_out == 24'd5 && flags_out == 6'b110101, "R12 parked count/flags", 32'(bc_out), 32'd5);
        v.ehl = 24'h106; v.ede = 24'h306; v.ebc = 24'd0; v.efl = 6'b110001;
        v.eic = 16'd6; v.nit = 8'd5; v.erd = 24'h101; v.ewr = 24'h301; v.nwr = 8'd5;
        v.cidx = 10'h305; v.cval = 8'h05;
        run(v, 0, 1'b1, 1'b0);
        check_vec(v, "resume");
        chk(r_susp == 1'b0, "R12 resume ends normally", 32'(r_susp), 32'd0);

        // R12: irq only outside update cycles has no effect
        mem_init();
        run(VECS[2], 2, 1'b0, 1'b0);
        check_vec(VECS[2], "irq-off-upd");
        chk(r_susp == 1'b0, "R12 irq outside update ignored", 32'(r_susp), 32'd0);

        // R12: irq on a single pass and on a final pass does not suspend
        mem_init();
        run(VECS[0], 1, 1'b0, 1'b0);
        check_vec(VECS[0], "irq-single");
        chk(r_susp == 1'b0, "R12 irq on single pass", 32'(r_susp), 32'd0);
        mem_init();
        v = VECS[1];
        v.bc = 24'd1; v.ehl = 24'h101; v.ede = 24'h301; v.efl = 6'b110001;
        v.eic = 16'd1; v.nit = 8'd1; v.nwr = 8'd1; v.cidx = 10'h300; v.cval = 8'h00;
        run(v, 1, 1'b0, 1'b0);
        check_vec(v, "irq-final");
        chk(r_susp == 1'b0, "R12 irq on final pass", 32'(r_susp), 32'd0);

        // R8 R12: parked repeating compare costs 2, total after resume 39
        mem_init();
        run(VECS[3], 1, 1'b0, 1'b0);
        chk(r_susp == 1'b1, "R12 compare parked", 32'(r_susp), 32'd1);
        chk(icycles == 16'd2, "R8 parked compare cost", 32'(icycles), 32'd2);
        chk(hl_out == 24'h11 && bc_out == 24'h3F, "R7 parked compare regs", 32'(hl_out), 32'h11);
        v = VECS[3];
        v.nit = 8'd19; v.erd = 24'h11;
        run(v, 0, 1'b1, 1'b0);
        check_vec(v, "cmp-resume");

        // R7: match and exhaustion on the same pass
        mem_init();
        v = VECS[4];
        v.acc = 8'h22; v.efl = 6'b010010; v.eic = 16'd5;
        run(v, 0, 1'b0, 1'b0);
        check_vec(v, "match-and-empty");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule